// File: doc/BRIEF.md
# Network Option Card Host Register Window

This block is the host-side register file of a plug-in network option card. The host I/O bus reaches the card through four word locations. The word index on the bus is captured into a holding register, and every later access is decoded from that held value. Read strobes and write strobes come from a separate bus clock. Each one passes through a two-flop synchronizer, and the block acts on its edges.

The location at offset 0 is a streaming window into one of two ROMs: an identification/option ROM and a station-address ROM. Each completed read advances an 8-bit ROM pointer, so software can read a whole ROM through a single address. A write to offset 2 rewinds the pointer, and so does the initialize input. Offset 4 holds a memory base register. Offset 6 holds a control/status register, and bit 0 of it selects which ROM the window shows.

Top module: `nic_regwin`

## Requirements
- R1: The word index `addr_i` (0..3, meaning byte offsets 0, 2, 4, 6) is sampled on every clock edge where `addr_le_i` is high. Decoding uses only this held index, so changes on `addr_i` while `addr_le_i` is low have no effect.
- R2: With index 0 held, `rdata_o` equals `rom_data_i`, and `rom_addr_o` equals the ROM pointer.
- R3: Each read strobe with index 0 held advances the pointer by one after the strobe ends, and the pointer wraps from 255 to 0. Reads at indices 1, 2 and 3 leave the pointer unchanged.
- R4: A read strobe advances the pointer exactly once, however many cycles it lasts.
- R5: Any write with index 1 held clears the pointer, whatever the data. With index 1 held, `rdata_o` is `{8'h00, pointer}`.
- R6: With index 2 held, a write loads the memory base register. It reads back on `rdata_o` and appears on `membase_o`.
- R7: With index 3 held, a write loads the control/status register. It reads back on `rdata_o` and appears on `csr_o`. Bit 0 drives `rom_sel_o`: 0 selects the ID ROM and 1 selects the station-address ROM.
- R8: While `init_i` is high, the pointer, the memory base register and the control/status register are held at zero, and writes to indices 1, 2 and 3 are ignored.
- R9: A write with index 0 held changes no register and does not move the pointer.
- R10: After `rst_ni` is released, the pointer, the held index, the memory base register and the control/status register are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 2 | Word index on the host bus |
| addr_le_i | input | 1 | Captures `addr_i` into the held index |
| rd_i | input | 1 | Read strobe, asynchronous |
| wr_i | input | 1 | Write strobe, asynchronous |
| wdata_i | input | 16 | Write data, held stable across the write strobe |
| init_i | input | 1 | Initialize, synchronous, level sensitive |
| rom_data_i | input | 16 | Data returned by the selected ROM |
| rdata_o | output | 16 | Read data for the held index |
| rom_addr_o | output | 8 | ROM pointer |
| rom_sel_o | output | 1 | ROM select: 0 selects the ID ROM, 1 the station-address ROM |
| membase_o | output | 16 | Memory base register |
| csr_o | output | 16 | Control/status register |

## Verification
`rom_addr_o` exposes the pointer directly. A missed advance, a double advance or a failed rewind therefore shows at the ports within a few cycles of the strobe's end, and it never corrects itself on later reads. A wrong held index shows at once on `rdata_o`, because the data comes back from the wrong location. A lost write or a register that `init_i` fails to clear stays visible on `membase_o` or `csr_o` until the next write to that register. A wrong ROM select shows as data from the other ROM.

// File: rtl/nic_regwin_pkg.sv
package nic_regwin_pkg;
  typedef enum logic [1:0] {
    OFF_ROM   = 2'd0,
    OFF_PTR   = 2'd1,
    OFF_MBASE = 2'd2,
    OFF_CSR   = 2'd3
  } reg_off_e;

  localparam int unsigned CSR_SEL_BIT = 0;
endpackage

// File: rtl/nic_regwin_sync.sv
module nic_regwin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= {q[STAGES-1:0], strobe_i};
  end

  assign rise_o = q[STAGES-1] & ~q[STAGES];
  assign fall_o = ~q[STAGES-1] & q[STAGES];

  // R4: an edge pulse lasts one cycle
  a_r4_single_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
  a_r4_single_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/nic_regwin_addr.sv
module nic_regwin_addr
  import nic_regwin_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] addr_i,
  input  logic       le_i,
  output reg_off_e   off_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   off_o <= OFF_ROM;
    else if (le_i) off_o <= reg_off_e'(addr_i);
  end

  // R1: the held index moves only on a capture
  a_r1_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !le_i |=> $stable(off_o));
endmodule

// File: rtl/nic_regwin_ptr.sv
module nic_regwin_ptr #(
  parameter int unsigned PTR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic             clr_i,
  input  logic             adv_i,
  output logic [PTR_W-1:0] ptr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                ptr_o <= '0;
    else if (init_i || clr_i)   ptr_o <= '0;
    else if (adv_i)             ptr_o <= ptr_o + 1'b1;
  end

  a_r8_init_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> ptr_o == '0);
  a_r5_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ptr_o == '0);
  a_r3_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !init_i && !clr_i) |=> ptr_o == $past(ptr_o) + 1'b1);
  a_r3_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !init_i && !clr_i) |=> $stable(ptr_o));
endmodule

// File: rtl/nic_regwin_regs.sv
module nic_regwin_regs
  import nic_regwin_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic              wr_i,
  input  reg_off_e          off_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] mbase_o,
  output logic [DATA_W-1:0] csr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mbase_o <= '0;
      csr_o   <= '0;
    end else if (init_i) begin
      mbase_o <= '0;
      csr_o   <= '0;
    end else if (wr_i) begin
      if (off_i == OFF_MBASE) mbase_o <= wdata_i;
      if (off_i == OFF_CSR)   csr_o   <= wdata_i;
    end
  end

  a_r8_init_regs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> (mbase_o == '0 && csr_o == '0));
  a_r6_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !init_i && off_i == OFF_MBASE) |=> mbase_o == $past(wdata_i));
  a_r9_rom_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !init_i && off_i == OFF_ROM) |=> ($stable(mbase_o) && $stable(csr_o)));
endmodule

// File: rtl/nic_regwin.sv
module nic_regwin
  import nic_regwin_pkg::*;
#(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned PTR_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        addr_i,
  input  logic              addr_le_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              init_i,
  input  logic [DATA_W-1:0] rom_data_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [PTR_W-1:0]  rom_addr_o,
  output logic              rom_sel_o,
  output logic [DATA_W-1:0] membase_o,
  output logic [DATA_W-1:0] csr_o
);
  localparam int unsigned PAD_W = DATA_W - PTR_W;

  reg_off_e         off;
  logic             rd_rise, rd_fall, wr_rise, wr_fall;
  logic             ptr_adv, ptr_clr;
  logic [PTR_W-1:0] ptr;

  nic_regwin_addr u_addr (
    .clk_i, .rst_ni, .addr_i, .le_i(addr_le_i), .off_o(off)
  );

  nic_regwin_sync #(.STAGES(SYNC_STAGES)) u_rd_sync (
    .clk_i, .rst_ni, .strobe_i(rd_i), .rise_o(rd_rise), .fall_o(rd_fall)
  );

  nic_regwin_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
    .clk_i, .rst_ni, .strobe_i(wr_i), .rise_o(wr_rise), .fall_o(wr_fall)
  );

  // advance after the read completes; rewind on write start
  assign ptr_adv = rd_fall && (off == OFF_ROM);
  assign ptr_clr = wr_rise && (off == OFF_PTR);

  nic_regwin_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk_i, .rst_ni, .init_i, .clr_i(ptr_clr), .adv_i(ptr_adv), .ptr_o(ptr)
  );

  nic_regwin_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni, .init_i, .wr_i(wr_rise), .off_i(off), .wdata_i,
    .mbase_o(membase_o), .csr_o(csr_o)
  );

  assign rom_addr_o = ptr;
  assign rom_sel_o  = csr_o[CSR_SEL_BIT];

  always_comb begin
    unique case (off)
      OFF_ROM:   rdata_o = rom_data_i;
      OFF_PTR:   rdata_o = {{PAD_W{1'b0}}, ptr};
      OFF_MBASE: rdata_o = membase_o;
      OFF_CSR:   rdata_o = csr_o;
      default:   rdata_o = '0;
    endcase
  end

  // R4: read and write edges in the same cycle are independent; reads never clear
  a_r4_no_double_adv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_adv |=> !ptr_adv);
  a_r3_rd_rise_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_rise && !wr_rise && !wr_fall && !init_i) |=> $stable(rom_addr_o));
endmodule

// File: tb/sim_nic_regwin.sv
`timescale 1ns/1ps
module sim_nic_regwin;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  addr_i = 2'd0;
  logic        addr_le_i = 1'b0, rd_i = 1'b0, wr_i = 1'b0, init_i = 1'b0;
  logic [15:0] wdata_i = 16'h0;
  logic [15:0] rom_data_i, rdata_o, membase_o, csr_o;
  logic [7:0]  rom_addr_o;
  logic        rom_sel_o;

  int n_vec = 0, n_bad = 0;
  bit settled = 1'b0, done = 1'b0;
  int m_ptr = 0, m_off = 0;
  logic [15:0] m_mbase = 16'h0, m_csr = 16'h0;
  bit m_init = 1'b0;

  always #2 clk = ~clk;

  function automatic logic [15:0] rom_word(logic sel, logic [7:0] a);
    return sel ? {8'h5A, a ^ 8'h3C} : {a, ~a};
  endfunction

  assign rom_data_i = rom_word(rom_sel_o, rom_addr_o);

  nic_regwin u0 (
    .clk_i(clk), .rst_ni, .addr_i, .addr_le_i, .rd_i, .wr_i, .wdata_i, .init_i,
    .rom_data_i, .rdata_o, .rom_addr_o, .rom_sel_o, .membase_o, .csr_o
  );

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] exp_rdata();
    case (m_off)
      0: return rom_word(m_csr[0], 8'(m_ptr));
      1: return {8'h00, 8'(m_ptr)};
      2: return m_mbase;
      default: return m_csr;
    endcase
  endfunction

  // reference comparison each cycle once the model is current
  always @(negedge clk) begin
    if (settled && rst_ni && !done) begin
      check("R3 rom_addr", {8'h00, rom_addr_o}, {8'h00, 8'(m_ptr)});
      check("R7 rom_sel", {15'h0, rom_sel_o}, {15'h0, m_csr[0]});
      check("R6 membase", membase_o, m_mbase);
      check("R7 csr", csr_o, m_csr);
      check("R1 rdata", rdata_o, exp_rdata());
    end
  end

  task automatic settle();
    repeat (6) @(posedge clk);
    #1 settled = 1'b1;
  endtask

  task automatic latch_off(int w);
    settled = 1'b0;
    @(posedge clk); #1 addr_i = 2'(w); addr_le_i = 1'b1;
    @(posedge clk); #1 addr_le_i = 1'b0;
    m_off = w;
    settle();
  endtask

  task automatic rd_pulse(int len);
    settled = 1'b0;
    @(posedge clk); #1 rd_i = 1'b1;
    repeat (len) @(posedge clk);
    #1 rd_i = 1'b0;
    if (m_init) m_ptr = 0;
    else if (m_off == 0) m_ptr = (m_ptr + 1) % 256;
    settle();
  endtask

  task automatic wr_pulse(logic [15:0] d);
    settled = 1'b0;
    @(posedge clk); #1 wdata_i = d; wr_i = 1'b1;
    repeat (3) @(posedge clk);
    #1 wr_i = 1'b0;
    repeat (4) @(posedge clk);
    if (!m_init) begin
      case (m_off)
        1: m_ptr = 0;
        2: m_mbase = d;
        3: m_csr = d;
        default: ;
      endcase
    end
    settle();
  endtask

  task automatic set_init(bit v);
    settled = 1'b0;
    @(posedge clk); #1 init_i = v;
    m_init = v;
    if (v) begin m_ptr = 0; m_mbase = 16'h0; m_csr = 16'h0; end
    settle();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 csr", csr_o, 16'h0);
    check("R10 membase", membase_o, 16'h0);
    check("R10 ptr", {8'h0, rom_addr_o}, 16'h0);
    check("R10 rdata", rdata_o, rom_word(1'b0, 8'h00));
    settled = 1'b1;

    // R2 / R3 ID ROM streaming
    latch_off(0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R2 rom window", rdata_o, rom_word(1'b0, 8'(i)));
      rd_pulse(2);
      check("R3 advance", {8'h0, rom_addr_o}, 16'(i + 1));
    end

    // R4 long strobe advances once
    rd_pulse(30);
    @(negedge clk);
    check("R4 long strobe", {8'h0, rom_addr_o}, 16'd5);

    // R5 pointer readback, R3 no advance at other index
    latch_off(1);
    @(negedge clk);
    check("R5 ptr readback", rdata_o, 16'h0005);
    rd_pulse(2);
    @(negedge clk);
    check("R3 other index", {8'h0, rom_addr_o}, 16'd5);
    wr_pulse(16'hFFFF);
    @(negedge clk);
    check("R5 rewind", {8'h0, rom_addr_o}, 16'd0);

    // R6 memory base
    latch_off(2);
    wr_pulse(16'h1234);
    @(negedge clk);
    check("R6 readback", rdata_o, 16'h1234);
    check("R6 port", membase_o, 16'h1234);

    // R7 station-address ROM
    latch_off(3);
    wr_pulse(16'h00C1);
    @(negedge clk);
    check("R7 sel", {15'h0, rom_sel_o}, 16'h1);
    latch_off(0);
    @(negedge clk);
    check("R7 station rom", rdata_o, rom_word(1'b1, 8'h00));
    rd_pulse(1);
    @(negedge clk);
    check("R7 station rom next", rdata_o, rom_word(1'b1, 8'h01));

    // R9 write at index 0
    wr_pulse(16'hBEEF);
    @(negedge clk);
    check("R9 ptr", {8'h0, rom_addr_o}, 16'd1);
    check("R9 membase", membase_o, 16'h1234);
    check("R9 csr", csr_o, 16'h00C1);

    // R1 held index ignores live bus
    latch_off(2);
    settled = 1'b0;
    @(posedge clk); #1 addr_i = 2'd0;
    settle();
    @(negedge clk);
    check("R1 held index", rdata_o, 16'h1234);

    // R8 init
    latch_off(3);
    wr_pulse(16'h0000);
    latch_off(0);
    rd_pulse(1); rd_pulse(1);
    set_init(1'b1);
    @(negedge clk);
    check("R8 ptr cleared", {8'h0, rom_addr_o}, 16'd0);
    check("R8 membase cleared", membase_o, 16'h0);
    latch_off(2);
    wr_pulse(16'h7777);
    @(negedge clk);
    check("R8 membase write ignored", membase_o, 16'h0);
    latch_off(3);
    wr_pulse(16'h0001);
    @(negedge clk);
    check("R8 csr write ignored", csr_o, 16'h0);
    set_init(1'b0);

    // R3 wrap
    latch_off(0);
    for (int i = 0; i < 255; i++) rd_pulse(1);
    @(negedge clk);
    check("R3 at 255", {8'h0, rom_addr_o}, 16'd255);
    rd_pulse(1);
    @(negedge clk);
    check("R3 wrap", {8'h0, rom_addr_o}, 16'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule